// File: doc/BRIEF.md
# Programmable Flow-Table State Controller

This block is a sequential controller whose transitions come entirely from a loadable table. No state graph is fixed in the logic. With the default parameters it holds a flow table of eight rows (one per 3-bit present-state code) and three input columns. Each entry is a 3-bit destination code. So any machine of up to eight states and three input conditions runs on the same gates. The table sits in a serial shift chain, which can be reloaded at any time to give the controller a new behaviour.

On every step, the input column picks one destination code per row. A one-hot decode of the present state then enables exactly one row path, and the chosen code is captured in the state flip-flops. Each next-state bit has its own AND-OR selector, and all of these selectors have the same shape. Rows that a given machine does not use should be loaded with code 000 in every column, so that a stray entry into them returns to the initial state.

Top module: `sm_flow_engine`

## Requirements
- R1: A high `rst` at a rising clock edge sets `state_q` to 000 and clears every table bit to 0, so every entry then leads to 000. Reset takes precedence over a shift in the same cycle, and the bit offered in that cycle is not taken.
- R2: While `load_en` is high, one bit of `load_bit` enters the table per clock. After 72 shifts, the bit of entry (row r, column c) with weight 2^b is the bit sent at position ((r*3)+c)*3+b, counting from 0 for the first bit sent.
- R3: While `load_en` is high, `state_q` keeps its value whatever `col_sel` is.
- R4: With `load_en` and `rst` low and `col_sel` equal to 0, 1 or 2, `state_q` takes, at the next edge, the table entry at the row of the present state and the column given by `col_sel`.
- R5: With `load_en` and `rst` low and `col_sel` equal to 3, `state_q` keeps its value.
- R6: All eight present-state codes, 110 and 111 included, have their own row, and a loaded machine may pass through them.
- R7: Loading a new table without a reset fully replaces the old transitions. The present state is kept across the load.
- R8: Each bit of the next state is selected on its own, so destination codes with mixed bit values (such as 101 and 010) appear exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| col_sel | input | 2 | Input column of the flow table; 3 means no column |
| load_en | input | 1 | Shift one table bit per clock and freeze the state |
| load_bit | input | 1 | Serial table data, first bit lands at the lowest table position |
| state_q | output | 3 | Present-state code |

## Verification
Two functions can meet in one cycle. A table shift can coincide with a valid step request, and a reset can coincide with a shift. The bench keeps `col_sel` on a live column during a whole reload and checks in every cycle that the state does not move. It also raises reset and `load_en` together with `load_bit` at 1, then shifts 71 zeros. If that bit had been taken it would now sit at row 0, column 0, weight 1, so a column-0 step from state 000 that still gives 000 shows that reset won.

// File: rtl/sm_tbl_pkg.sv
`timescale 1ns/1ps
package sm_tbl_pkg;
   localparam int unsigned DEF_STATE_W  = 3;
   localparam int unsigned DEF_NUM_COLS = 3;

   // position of the lowest bit of one table entry
   function automatic int unsigned entry_base(input int unsigned row,
                                              input int unsigned col,
                                              input int unsigned ncols,
                                              input int unsigned sw);
      return (row * ncols + col) * sw;
   endfunction
endpackage

// File: rtl/sm_dest_chain.sv
`timescale 1ns/1ps
module sm_dest_chain #(
   parameter int unsigned LEN = 72
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           shift_en,
   input  logic           bit_in,
   output logic [LEN-1:0] bits_q
);
   if (LEN < 2) begin : g_len_bad
      $error("sm_dest_chain: LEN must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst)
         bits_q <= '0;
      else if (shift_en)
         bits_q <= {bit_in, bits_q[LEN-1:1]};
   end
endmodule

// File: rtl/sm_col_switch.sv
`timescale 1ns/1ps
module sm_col_switch
   import sm_tbl_pkg::*;
#(
   parameter int unsigned STATE_W  = 3,
   parameter int unsigned NUM_COLS = 3,
   parameter int unsigned COL_W    = 2,
   parameter int unsigned NUM_ROWS = 8,
   localparam int unsigned TBL_BITS = NUM_ROWS * NUM_COLS * STATE_W
) (
   input  logic [TBL_BITS-1:0]               tbl,
   input  logic [COL_W-1:0]                  col_sel,
   output logic [NUM_ROWS-1:0][STATE_W-1:0]  cand,
   output logic                              col_ok
);
   logic [NUM_COLS-1:0] col_hot;

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      assign col_hot[c] = (col_sel == COL_W'(c));
   end

   assign col_ok = |col_hot;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      always_comb begin
         cand[r] = '0;
         for (int c = 0; c < NUM_COLS; c++) begin
            cand[r] = cand[r] |
               (tbl[entry_base(r, c, NUM_COLS, STATE_W) +: STATE_W] & {STATE_W{col_hot[c]}});
         end
      end
   end
endmodule

// File: rtl/sm_row_decode.sv
`timescale 1ns/1ps
module sm_row_decode #(
   parameter int unsigned STATE_W  = 3,
   parameter int unsigned NUM_ROWS = 8
) (
   input  logic [STATE_W-1:0]  state,
   output logic [NUM_ROWS-1:0] row_hot
);
   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_dec
      assign row_hot[r] = (state == STATE_W'(r));
   end
endmodule

// File: rtl/sm_next_select.sv
`timescale 1ns/1ps
module sm_next_select #(
   parameter int unsigned STATE_W  = 3,
   parameter int unsigned NUM_ROWS = 8
) (
   input  logic [NUM_ROWS-1:0]               row_hot,
   input  logic [NUM_ROWS-1:0][STATE_W-1:0]  cand,
   output logic [STATE_W-1:0]                nxt
);
   for (genvar b = 0; b < STATE_W; b++) begin : g_bit
      logic [NUM_ROWS-1:0] terms;
      for (genvar r = 0; r < NUM_ROWS; r++) begin : g_path
         assign terms[r] = row_hot[r] & cand[r][b];
      end
      assign nxt[b] = |terms;
   end
endmodule

// File: rtl/sm_flow_engine.sv
`timescale 1ns/1ps
module sm_flow_engine
   import sm_tbl_pkg::*;
#(
   parameter int unsigned STATE_W        = DEF_STATE_W,
   parameter int unsigned NUM_COLS       = DEF_NUM_COLS,
   parameter bit          SPARE_COL_HOLD = 1'b1,
   localparam int unsigned NUM_ROWS = 1 << STATE_W,
   localparam int unsigned COL_W    = $clog2(NUM_COLS + 1),
   localparam int unsigned TBL_BITS = NUM_ROWS * NUM_COLS * STATE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [COL_W-1:0]   col_sel,
   input  logic               load_en,
   input  logic               load_bit,
   output logic [STATE_W-1:0] state_q
);
   if (STATE_W < 1 || STATE_W > 6) begin : g_sw_bad
      $error("sm_flow_engine: STATE_W out of range 1..6");
   end
   if (NUM_COLS < 1) begin : g_nc_bad
      $error("sm_flow_engine: NUM_COLS must be at least 1");
   end

   logic [TBL_BITS-1:0]              tbl_bits;
   logic [NUM_ROWS-1:0][STATE_W-1:0] cand;
   logic                             col_ok;
   logic [NUM_ROWS-1:0]              row_hot;
   logic [STATE_W-1:0]               sel_nxt;
   logic [STATE_W-1:0]               spare_d;
   logic [STATE_W-1:0]               step_d;

   sm_dest_chain #(.LEN(TBL_BITS)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (load_en),
      .bit_in   (load_bit),
      .bits_q   (tbl_bits)
   );

   sm_col_switch #(
      .STATE_W  (STATE_W),
      .NUM_COLS (NUM_COLS),
      .COL_W    (COL_W),
      .NUM_ROWS (NUM_ROWS)
   ) u_cols (
      .tbl     (tbl_bits),
      .col_sel (col_sel),
      .cand    (cand),
      .col_ok  (col_ok)
   );

   sm_row_decode #(.STATE_W(STATE_W), .NUM_ROWS(NUM_ROWS)) u_dec (
      .state   (state_q),
      .row_hot (row_hot)
   );

   sm_next_select #(.STATE_W(STATE_W), .NUM_ROWS(NUM_ROWS)) u_sel (
      .row_hot (row_hot),
      .cand    (cand),
      .nxt     (sel_nxt)
   );

   if (SPARE_COL_HOLD) begin : g_spare_hold
      assign spare_d = state_q;
   end else begin : g_spare_init
      assign spare_d = '0;
   end

   assign step_d = col_ok ? sel_nxt : spare_d;

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= '0;
      else if (!load_en)
         state_q <= step_d;
   end
endmodule

// File: rtl/sm_flow_engine_chk.sv
`timescale 1ns/1ps
module sm_flow_engine_chk #(
   parameter int unsigned STATE_W        = 3,
   parameter int unsigned NUM_COLS       = 3,
   parameter bit          SPARE_COL_HOLD = 1'b1,
   localparam int unsigned NUM_ROWS = 1 << STATE_W,
   localparam int unsigned COL_W    = $clog2(NUM_COLS + 1),
   localparam int unsigned TBL_BITS = NUM_ROWS * NUM_COLS * STATE_W
) (
   input logic                clk,
   input logic                rst,
   input logic [COL_W-1:0]    col_sel,
   input logic                load_en,
   input logic                load_bit,
   input logic [STATE_W-1:0]  state_q,
   input logic [TBL_BITS-1:0] tbl_bits,
   input logic [NUM_ROWS-1:0] row_hot
);
   logic               col_in;
   int unsigned        col_i;
   logic [STATE_W-1:0] exp_nxt;

   always_comb begin
      col_in = (int'(col_sel) < int'(NUM_COLS));
      col_i  = col_in ? int'(col_sel) : 0;
      if (col_in)
         exp_nxt = tbl_bits[(int'(state_q) * NUM_COLS + col_i) * STATE_W +: STATE_W];
      else
         exp_nxt = SPARE_COL_HOLD ? state_q : '0;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (state_q == '0 && tbl_bits == '0));

   // R2
   shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
      load_en |=> tbl_bits[TBL_BITS-1] == $past(load_bit));

   // R7
   table_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> $stable(tbl_bits));

   // R3
   load_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      load_en |=> $stable(state_q));

   // R4
   step_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (!load_en && col_in) |=> state_q == $past(exp_nxt));

   // R5
   spare_col_chk: assert property (@(posedge clk) disable iff (rst)
      (!load_en && !col_in) |=> state_q == $past(exp_nxt));

   // R6
   one_row_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(row_hot) == 1);
endmodule

bind sm_flow_engine sm_flow_engine_chk #(
   .STATE_W        (STATE_W),
   .NUM_COLS       (NUM_COLS),
   .SPARE_COL_HOLD (SPARE_COL_HOLD)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .col_sel  (col_sel),
   .load_en  (load_en),
   .load_bit (load_bit),
   .state_q  (state_q),
   .tbl_bits (tbl_bits),
   .row_hot  (row_hot)
);

// File: tb/test_sm_flow_engine.sv
`timescale 1ns/1ps
module test_sm_flow_engine;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] col_sel = 2'd3;
   logic       load_en = 1'b0;
   logic       load_bit = 1'b0;
   logic [2:0] state_q;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sm_flow_engine i_sm_flow_engine (
      .clk(clk), .rst(rst), .col_sel(col_sel),
      .load_en(load_en), .load_bit(load_bit), .state_q(state_q)
   );

   // {col_sel, expected state} for table A, starting from 000
   localparam logic [4:0] VEC_A [0:11] = '{
      {2'd0,3'd1}, {2'd0,3'd2}, {2'd1,3'd4}, {2'd2,3'd3},
      {2'd2,3'd2}, {2'd3,3'd2}, {2'd1,3'd4}, {2'd1,3'd0},
      {2'd2,3'd5}, {2'd0,3'd0}, {2'd1,3'd2}, {2'd2,3'd1}
   };
   // table B walk starting from 001
   localparam logic [4:0] VEC_B [0:5] = '{
      {2'd0,3'd0}, {2'd0,3'd7}, {2'd0,3'd6},
      {2'd1,3'd5}, {2'd2,3'd2}, {2'd2,3'd0}
   };

   function automatic logic [71:0] put(input logic [71:0] t, input int r,
                                      input int c, input logic [2:0] v);
      logic [71:0] o = t;
      for (int b = 0; b < 3; b++) o[((r*3)+c)*3+b] = v[b];
      return o;
   endfunction

   // table A: rows 0..5 advance by 1, 2 or 5 modulo 6; rows 6,7 go to 000
   function automatic logic [71:0] table_a();
      logic [71:0] t = '0;
      int step [3] = '{1, 2, 5};
      for (int r = 0; r < 6; r++)
         for (int c = 0; c < 3; c++)
            t = put(t, r, c, 3'((r + step[c]) % 6));
      return t;
   endfunction

   // table B: uses the upper rows, everything else 000
   function automatic logic [71:0] table_b();
      logic [71:0] t = '0;
      t = put(t, 0, 0, 3'd7);
      t = put(t, 7, 0, 3'd6);
      t = put(t, 6, 1, 3'd5);
      t = put(t, 5, 2, 3'd2);
      return t;
   endfunction

   task automatic check(input string req, input logic [2:0] exp);
      checks++;
      if (state_q !== exp) begin
         errors++;
         $display("FAIL %s: state_q=%0d expected=%0d", req, state_q, exp);
      end
   endtask

   // shift a table while col_sel sits on column c; state must stay put (R3)
   task automatic load_table(input logic [71:0] t, input logic [1:0] c);
      logic [2:0] held = state_q;
      col_sel = c;
      for (int i = 0; i < 72; i++) begin
         load_en = 1'b1;
         load_bit = t[i];
         @(posedge clk); #1;
         check("R3", held);
      end
      load_en = 1'b0;
      load_bit = 1'b0;
   endtask

   task automatic step(input logic [1:0] c, input logic [2:0] exp, input string req);
      col_sel = c;
      @(posedge clk); #1;
      check(req, exp);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", 3'd0);
      rst = 1'b0;

      // R2 R4 R5: program table A and walk it
      load_table(table_a(), 2'd1);
      foreach (VEC_A[i])
         step(VEC_A[i][4:3], VEC_A[i][2:0], (VEC_A[i][4:3] == 2'd3) ? "R5" : "R4");

      // R7 R3: reload with table B while state is 001 and a live column is set
      load_table(table_b(), 2'd0);
      check("R7", 3'd1);
      // R6 R8: upper rows and mixed-bit codes
      foreach (VEC_B[i])
         step(VEC_B[i][4:3], VEC_B[i][2:0], (i >= 1 && i <= 4) ? "R6_R8" : "R7");

      // R1: reset wins over a shift offered in the same cycle
      load_table(table_a(), 2'd3);
      step(2'd0, 3'd1, "R4");
      rst = 1'b1; load_en = 1'b1; load_bit = 1'b1;
      @(posedge clk); #1;
      check("R1", 3'd0);
      rst = 1'b0;
      for (int i = 0; i < 71; i++) begin
         load_bit = 1'b0;
         @(posedge clk); #1;
      end
      load_en = 1'b0;
      step(2'd0, 3'd0, "R1");

      // R1: plain reset clears a loaded table
      load_table(table_a(), 2'd2);
      step(2'd0, 3'd1, "R4");
      step(2'd1, 3'd3, "R4");
      rst = 1'b1;
      @(posedge clk); #1;
      check("R1", 3'd0);
      rst = 1'b0;
      step(2'd0, 3'd0, "R1");
      step(2'd2, 3'd0, "R1");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule